// File: doc/BRIEF.md
# Stack Push/Pull Engine

This block carries out the four one-byte stack instructions of an 8-bit processor core. Two of them store a register into the stack: the accumulator or the processor status. The other two load a register back from the stack. The block holds the 8-bit stack pointer. The stack always lives in memory page one, so every access goes to an address whose upper byte is 0x01 and whose lower byte is the pointer.

The surrounding core pulses `start` together with an opcode. The engine then steps through a fixed sequence of two or three cycles. During that sequence it drives a byte-wide memory port, and the core's memory answers a read one cycle after the address is presented. For a pull, the engine returns the new accumulator or status value with a one-cycle load strobe. The core supplies the current accumulator and status on its inputs. `done` marks the last cycle of every instruction.

Top module: `stack_engine`

## Requirements
- R1: Only the opcodes 0x48 (push accumulator), 0x68 (pull accumulator), 0x08 (push status) and 0x28 (pull status) start a sequence. A start with any other opcode leaves `busy`, `mem_we` and the pointer unchanged.
- R2: Every memory access addresses {0x01, stack pointer}. The upper address byte is 0x01 at all times.
- R3: A push takes two cycles. In the cycle after start, the address is presented and `mem_we` is 0. In the second cycle, `mem_we`, `done` and the write data are driven. The pointer then decrements, and 0x00 wraps to 0xFF.
- R4: A status push writes `stat_in` with bit 4 and bit 5 forced to 1.
- R5: A pull takes three cycles. The pointer increments at the end of the first cycle, and 0xFF wraps to 0x00. The second cycle addresses the new pointer. In the third cycle, `mem_rdata` holds the byte from that address, and the engine raises `done` and the load strobe.
- R6: Pull accumulator puts the byte on `acc_out` with `acc_load`. It also drives `stat_out` = `stat_in` with bit 1 (zero) set exactly when the byte is 0 and bit 7 (negative) equal to the byte's bit 7, with `stat_load`.
- R7: Pull status drives `stat_out` = the byte, except that bits 5 and 4 keep the values of `stat_in`. It raises `stat_load` and leaves `acc_load` at 0.
- R8: Reset sets the pointer to 0xFD. It clears `busy`, `done`, `mem_we` and both load strobes, and it abandons any sequence in progress.
- R9: `mem_we` is high only in the second cycle of a push. A `start` received while a sequence runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request, sampled with `opcode` |
| opcode | input | 8 | Instruction code |
| acc_in | input | 8 | Current accumulator |
| stat_in | input | 8 | Current processor status |
| mem_rdata | input | 8 | Read data, one cycle after the address |
| mem_addr | output | 16 | Stack address {0x01, pointer} |
| mem_wdata | output | 8 | Byte to store |
| mem_we | output | 1 | Write enable |
| acc_out | output | 8 | Loaded accumulator value |
| acc_load | output | 1 | Accumulator load strobe |
| stat_out | output | 8 | Loaded or updated status value |
| stat_load | output | 1 | Status load strobe |
| stack_ptr | output | 8 | Current stack pointer |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Final cycle of the instruction |

## Verification
A pointer that moves at the wrong time shows up on `mem_addr` within the same instruction. It also shows on `stack_ptr` in the first idle cycle after that instruction. A phase counter that loses its place either moves `done` to a different cycle or raises `mem_we` during a pull, and both can be seen in the cycle where they happen. Wrong flag or bit-forcing logic appears only on the strobe cycle of the affected instruction. The most lasting symptom is a stacked byte that comes back wrong on a later pull, so the bench pushes values and pulls them back again.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam int STK_DW = 8;

  localparam logic [STK_DW-1:0] OPC_PUSH_ACC  = 8'h48;
  localparam logic [STK_DW-1:0] OPC_PULL_ACC  = 8'h68;
  localparam logic [STK_DW-1:0] OPC_PUSH_STAT = 8'h08;
  localparam logic [STK_DW-1:0] OPC_PULL_STAT = 8'h28;

  typedef enum logic [1:0] {
    K_PUSH_ACC,
    K_PULL_ACC,
    K_PUSH_STAT,
    K_PULL_STAT
  } stk_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ONE,
    PH_TWO,
    PH_THREE
  } stk_phase_e;

  function automatic logic kind_is_push(input stk_kind_e k);
    return (k == K_PUSH_ACC) || (k == K_PUSH_STAT);
  endfunction

  // Pointer arithmetic on the full byte; wraparound is the natural overflow.
  function automatic logic [STK_DW-1:0] ptr_down(input logic [STK_DW-1:0] p);
    return p - 1'b1;
  endfunction

  function automatic logic [STK_DW-1:0] ptr_up(input logic [STK_DW-1:0] p);
    return p + 1'b1;
  endfunction

  // Stored status image: two marker bits forced high.
  function automatic logic [STK_DW-1:0] stat_to_stack(input logic [STK_DW-1:0] s,
                                                      input int b_pos, input int u_pos);
    logic [STK_DW-1:0] r;
    r = s;
    r[b_pos] = 1'b1;
    r[u_pos] = 1'b1;
    return r;
  endfunction

  // Restored status: marker bits come from the live register, not the stack.
  function automatic logic [STK_DW-1:0] stat_from_stack(input logic [STK_DW-1:0] v,
                                                        input logic [STK_DW-1:0] live,
                                                        input int b_pos, input int u_pos);
    logic [STK_DW-1:0] r;
    r = v;
    r[b_pos] = live[b_pos];
    r[u_pos] = live[u_pos];
    return r;
  endfunction

  // Zero and negative flags after loading a value.
  function automatic logic [STK_DW-1:0] flags_after_load(input logic [STK_DW-1:0] live,
                                                         input logic [STK_DW-1:0] v,
                                                         input int n_pos, input int z_pos);
    logic [STK_DW-1:0] r;
    r = live;
    r[n_pos] = v[STK_DW-1];
    r[z_pos] = (v == '0);
    return r;
  endfunction

endpackage

// File: rtl/stk_decode.sv
module stk_decode
  import stk_pkg::*;
(
  input  logic [STK_DW-1:0] opcode,
  output logic              op_valid,
  output stk_kind_e         op_kind
);

  always_comb begin
    op_valid = 1'b1;
    op_kind  = K_PUSH_ACC;
    unique case (opcode)
      OPC_PUSH_ACC:  op_kind = K_PUSH_ACC;
      OPC_PULL_ACC:  op_kind = K_PULL_ACC;
      OPC_PUSH_STAT: op_kind = K_PUSH_STAT;
      OPC_PULL_STAT: op_kind = K_PULL_STAT;
      default:       op_valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/stk_sequencer.sv
module stk_sequencer
  import stk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       op_valid,
  input  stk_kind_e  op_kind,
  output stk_kind_e  kind_q,
  output logic       busy,
  output logic       done,
  output logic       push_commit,
  output logic       pull_bump,
  output logic       pull_capture
);

  stk_phase_e phase_q, phase_d;
  stk_kind_e  kind_d;
  logic       accept;
  logic       is_push;

  assign is_push = kind_is_push(kind_q);
  assign accept  = start && op_valid && (phase_q == PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    kind_d  = kind_q;
    unique case (phase_q)
      PH_IDLE:  if (accept) begin
                  phase_d = PH_ONE;
                  kind_d  = op_kind;
                end
      PH_ONE:   phase_d = PH_TWO;
      PH_TWO:   phase_d = is_push ? PH_IDLE : PH_THREE;
      PH_THREE: phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      kind_q  <= K_PUSH_ACC;
    end else begin
      phase_q <= phase_d;
      kind_q  <= kind_d;
    end
  end

  assign busy         = (phase_q != PH_IDLE);
  assign push_commit  = (phase_q == PH_TWO) && is_push;
  assign pull_bump    = (phase_q == PH_ONE) && !is_push;
  assign pull_capture = (phase_q == PH_THREE);
  assign done         = push_commit || pull_capture;

  // R3: the write cycle of a push directly follows the address cycle
  assert_push_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_commit |-> $past(phase_q) == PH_ONE);

  // R5: the capture cycle of a pull comes right after its address cycle
  assert_pull_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pull_capture |-> $past(phase_q) == PH_TWO && !kind_is_push(kind_q));

  // R9: a start while busy does not change the instruction being run
  assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(kind_q));

  // R3: done ends the sequence
  assert_done_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/stk_pointer.sv
module stk_pointer
  import stk_pkg::*;
#(
  parameter logic [STK_DW-1:0] SP_RESET = 8'hFD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_commit,
  input  logic              pull_bump,
  output logic [STK_DW-1:0] sp
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           sp <= SP_RESET;
    else if (push_commit) sp <= ptr_down(sp);
    else if (pull_bump)   sp <= ptr_up(sp);
  end

  // R3: a push leaves the pointer one lower, modulo 256
  assert_push_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_commit |=> sp == STK_DW'($past(sp) - 8'd1));

  // R5: a pull raises the pointer by one, modulo 256
  assert_pull_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pull_bump |=> sp == STK_DW'($past(sp) + 8'd1));

  // R9: the pointer holds outside the two update events
  assert_sp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_commit || pull_bump) |=> $stable(sp));

endmodule

// File: rtl/stk_datapath.sv
module stk_datapath
  import stk_pkg::*;
#(
  parameter int N_BIT = 7,
  parameter int Z_BIT = 1,
  parameter int B_BIT = 4,
  parameter int U_BIT = 5
) (
  input  stk_kind_e         kind_q,
  input  logic              push_commit,
  input  logic              pull_capture,
  input  logic [STK_DW-1:0] acc_in,
  input  logic [STK_DW-1:0] stat_in,
  input  logic [STK_DW-1:0] mem_rdata,
  output logic [STK_DW-1:0] mem_wdata,
  output logic              mem_we,
  output logic [STK_DW-1:0] acc_out,
  output logic              acc_load,
  output logic [STK_DW-1:0] stat_out,
  output logic              stat_load
);

  logic to_acc;

  assign to_acc    = (kind_q == K_PULL_ACC);
  assign mem_we    = push_commit;
  assign mem_wdata = (kind_q == K_PUSH_STAT) ? stat_to_stack(stat_in, B_BIT, U_BIT) : acc_in;

  always_comb begin
    acc_out   = acc_in;
    acc_load  = 1'b0;
    stat_out  = stat_in;
    stat_load = 1'b0;
    if (pull_capture) begin
      stat_load = 1'b1;
      if (to_acc) begin
        acc_out  = mem_rdata;
        acc_load = 1'b1;
        stat_out = flags_after_load(stat_in, mem_rdata, N_BIT, Z_BIT);
      end else begin
        stat_out = stat_from_stack(mem_rdata, stat_in, B_BIT, U_BIT);
      end
    end
  end

  // R4: the stored status image always carries both marker bits
  always_comb begin
    if (mem_we && kind_q == K_PUSH_STAT)
      assert_push_marks_R4: assert (mem_wdata[B_BIT] && mem_wdata[U_BIT]);
  end

  // R7: a restored status keeps the live marker bits
  always_comb begin
    if (stat_load && !acc_load)
      assert_pull_marks_R7: assert (stat_out[B_BIT] == stat_in[B_BIT] &&
                                    stat_out[U_BIT] == stat_in[U_BIT]);
  end

  // R9: no write while a pull returns data
  always_comb begin
    assert_no_write_on_load_R9: assert (!(mem_we && (acc_load || stat_load)));
  end

endmodule

// File: rtl/stack_engine.sv
module stack_engine
  import stk_pkg::*;
#(
  parameter logic [STK_DW-1:0] PAGE_HI  = 8'h01,
  parameter logic [STK_DW-1:0] SP_RESET = 8'hFD,
  parameter int                N_BIT    = 7,
  parameter int                Z_BIT    = 1,
  parameter int                B_BIT    = 4,
  parameter int                U_BIT    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [STK_DW-1:0]   opcode,
  input  logic [STK_DW-1:0]   acc_in,
  input  logic [STK_DW-1:0]   stat_in,
  input  logic [STK_DW-1:0]   mem_rdata,
  output logic [2*STK_DW-1:0] mem_addr,
  output logic [STK_DW-1:0]   mem_wdata,
  output logic                mem_we,
  output logic [STK_DW-1:0]   acc_out,
  output logic                acc_load,
  output logic [STK_DW-1:0]   stat_out,
  output logic                stat_load,
  output logic [STK_DW-1:0]   stack_ptr,
  output logic                busy,
  output logic                done
);

  logic      op_valid;
  stk_kind_e op_kind;
  stk_kind_e kind_q;
  logic      push_commit;
  logic      pull_bump;
  logic      pull_capture;
  logic [STK_DW-1:0] sp;

  stk_decode u_decode (
    .opcode   (opcode),
    .op_valid (op_valid),
    .op_kind  (op_kind)
  );

  stk_sequencer u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .op_valid     (op_valid),
    .op_kind      (op_kind),
    .kind_q       (kind_q),
    .busy         (busy),
    .done         (done),
    .push_commit  (push_commit),
    .pull_bump    (pull_bump),
    .pull_capture (pull_capture)
  );

  stk_pointer #(.SP_RESET(SP_RESET)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_commit (push_commit),
    .pull_bump   (pull_bump),
    .sp          (sp)
  );

  stk_datapath #(
    .N_BIT(N_BIT), .Z_BIT(Z_BIT), .B_BIT(B_BIT), .U_BIT(U_BIT)
  ) u_dp (
    .kind_q       (kind_q),
    .push_commit  (push_commit),
    .pull_capture (pull_capture),
    .acc_in       (acc_in),
    .stat_in      (stat_in),
    .mem_rdata    (mem_rdata),
    .mem_wdata    (mem_wdata),
    .mem_we       (mem_we),
    .acc_out      (acc_out),
    .acc_load     (acc_load),
    .stat_out     (stat_out),
    .stat_load    (stat_load)
  );

  assign mem_addr  = {PAGE_HI, sp};
  assign stack_ptr = sp;

  // R2: writes land in the stack page
  assert_write_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[2*STK_DW-1:STK_DW] == PAGE_HI);

  // R1: an unknown opcode from idle does not start a sequence
  assert_bad_opcode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !op_valid) |=> !busy);

  // R9: done and write strobes stay single-cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !mem_we);

endmodule

// File: tb/stack_engine_bench.sv
module stack_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [7:0]  acc_in = 8'h00;
  logic [7:0]  stat_in = 8'h00;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [7:0]  acc_out;
  logic        acc_load;
  logic [7:0]  stat_out;
  logic        stat_load;
  logic [7:0]  stack_ptr;
  logic        busy;
  logic        done;

  int checks = 0;
  int fails  = 0;
  logic [7:0] sp_m = 8'hFD;

  logic       pl_en = 1'b0;
  logic [7:0] pl_a  = 8'h00;
  logic [7:0] pl_d  = 8'h00;
  logic [7:0] page [256];

  always #4 clk = ~clk;

  stack_engine u_stack_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .acc_in(acc_in), .stat_in(stat_in), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .acc_out(acc_out), .acc_load(acc_load), .stat_out(stat_out),
    .stat_load(stat_load), .stack_ptr(stack_ptr), .busy(busy), .done(done)
  );

  // Page-one memory with one cycle of read latency
  always @(posedge clk) begin
    if (!rst_n && !pl_en) begin
      for (int i = 0; i < 256; i++) page[i] <= 8'hEE;
    end else if (mem_we) begin
      page[mem_addr[7:0]] <= mem_wdata;
    end else if (pl_en) begin
      page[pl_a] <= pl_d;
    end
    mem_rdata <= page[mem_addr[7:0]];
  end

  typedef struct packed {
    logic [7:0] op;
    logic [7:0] a;
    logic [7:0] p;
    logic [7:0] exp_byte;
    logic [7:0] exp_stat;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{8'h48, 8'h5A, 8'h00, 8'h5A, 8'h00},
    '{8'h08, 8'h00, 8'hC3, 8'hF3, 8'h00},
    '{8'h48, 8'h00, 8'h00, 8'h00, 8'h00},
    '{8'h68, 8'h00, 8'h82, 8'h00, 8'h02},
    '{8'h28, 8'h00, 8'h00, 8'hC3, 8'h00},
    '{8'h68, 8'h00, 8'h00, 8'h5A, 8'h00},
    '{8'h08, 8'h00, 8'h00, 8'h30, 8'h00},
    '{8'h28, 8'h00, 8'h10, 8'h10, 8'h00},
    '{8'h68, 8'h00, 8'h00, 8'h80, 8'h80}
  };

  function automatic void summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic preload(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    pl_en = 1'b1; pl_a = a; pl_d = d;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  task automatic do_op(input logic [7:0] op, input logic [7:0] a, input logic [7:0] p,
                       input logic [7:0] exp_byte, input logic [7:0] exp_stat);
    logic is_push;
    is_push = (op == 8'h48) || (op == 8'h08);
    @(negedge clk);
    opcode = op; acc_in = a; stat_in = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", "no write in first cycle", {15'd0, mem_we}, 16'd0);
    chk("R1", "busy after legal start", {15'd0, busy}, 16'd1);
    if (is_push) begin
      chk("R2", "push address cycle", mem_addr, {8'h01, sp_m});
      @(negedge clk);
      chk("R2", "push write address", mem_addr, {8'h01, sp_m});
      chk("R3", "push write enable", {15'd0, mem_we}, 16'd1);
      chk("R3", "push done", {15'd0, done}, 16'd1);
      if (op == 8'h08) chk("R4", "status image", {8'd0, mem_wdata}, {8'd0, exp_byte});
      else             chk("R3", "accumulator image", {8'd0, mem_wdata}, {8'd0, exp_byte});
      @(negedge clk);
      sp_m = sp_m - 8'd1;
      chk("R3", "pointer after push", {8'd0, stack_ptr}, {8'd0, sp_m});
      chk("R3", "idle after push", {14'd0, busy, done}, 16'd0);
    end else begin
      @(negedge clk);
      chk("R5", "pull address uses raised pointer", mem_addr, {8'h01, 8'(sp_m + 8'd1)});
      chk("R9", "no write during pull", {15'd0, mem_we}, 16'd0);
      @(negedge clk);
      chk("R5", "pull done", {15'd0, done}, 16'd1);
      if (op == 8'h68) begin
        chk("R6", "acc strobe", {15'd0, acc_load}, 16'd1);
        chk("R6", "acc value", {8'd0, acc_out}, {8'd0, exp_byte});
        chk("R6", "flag strobe", {15'd0, stat_load}, 16'd1);
        chk("R6", "flag value", {8'd0, stat_out}, {8'd0, exp_stat});
      end else begin
        chk("R7", "no acc strobe", {15'd0, acc_load}, 16'd0);
        chk("R7", "status strobe", {15'd0, stat_load}, 16'd1);
        chk("R7", "status value", {8'd0, stat_out}, {8'd0, exp_byte});
      end
      @(negedge clk);
      sp_m = sp_m + 8'd1;
      chk("R5", "pointer after pull", {8'd0, stack_ptr}, {8'd0, sp_m});
      chk("R5", "idle after pull", {14'd0, busy, done}, 16'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset values
    chk("R8", "reset pointer", {8'd0, stack_ptr}, 16'h00FD);
    chk("R8", "reset strobes", {11'd0, busy, done, mem_we, acc_load, stat_load}, 16'd0);
    chk("R2", "idle address", mem_addr, 16'h01FD);
    rst_n = 1'b1;
    preload(8'hFE, 8'h80);
    preload(8'hFF, 8'h00);
    preload(8'h00, 8'h7F);

    for (int i = 0; i < NVEC; i++)
      do_op(VECS[i].op, VECS[i].a, VECS[i].p, VECS[i].exp_byte, VECS[i].exp_stat);

    // R5 / R6: pulls across the top of the page, pointer wraps FF -> 00
    do_op(8'h68, 8'h00, 8'h80, 8'h00, 8'h02);
    do_op(8'h68, 8'h00, 8'h02, 8'h7F, 8'h00);
    chk("R5", "wrap to zero", {8'd0, stack_ptr}, 16'h0000);
    // R3: push at pointer 00 writes 0x0100 then wraps to FF
    do_op(8'h48, 8'h11, 8'h00, 8'h11, 8'h00);
    chk("R3", "wrap to FF", {8'd0, stack_ptr}, 16'h00FF);

    // R1: unknown opcode is ignored
    @(negedge clk);
    opcode = 8'hEA; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1", "no busy on bad opcode", {15'd0, busy}, 16'd0);
    repeat (3) begin
      chk("R1", "no write on bad opcode", {15'd0, mem_we}, 16'd0);
      @(negedge clk);
    end
    chk("R1", "pointer kept on bad opcode", {8'd0, stack_ptr}, 16'h00FF);

    // R9: start while busy is ignored
    @(negedge clk);
    opcode = 8'h48; acc_in = 8'h22; start = 1'b1;
    @(negedge clk);
    opcode = 8'h68;
    @(negedge clk);
    start = 1'b0;
    chk("R9", "push runs on", {15'd0, mem_we}, 16'd1);
    chk("R9", "push data kept", {8'd0, mem_wdata}, 16'h0022);
    @(negedge clk);
    chk("R9", "second start dropped", {15'd0, busy}, 16'd0);
    chk("R9", "pointer after ignored start", {8'd0, stack_ptr}, 16'h00FE);

    // R8: reset in the middle of a pull
    @(negedge clk);
    opcode = 8'h68; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8", "pointer after mid-op reset", {8'd0, stack_ptr}, 16'h00FD);
    chk("R8", "idle after mid-op reset", {13'd0, busy, done, mem_we}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8", "stays idle", {14'd0, busy, stat_load}, 16'd0);

    summary();
    $finish;
  end

endmodule